// File: doc/BRIEF.md
# Timer/Counter and Watchdog with Shared Prescaler

This block holds an 8-bit real-time counter and a watchdog counter. One 8-bit prescaler serves both, and a mode register decides which of the two owns it. The counter can advance on instruction-cycle ticks. It can also advance on edges of an external pin, and the active edge is selectable. The pin passes through a synchroniser before its edges are detected.

The watchdog advances on a free-running base tick. It is enabled in one of two ways: by a configuration input that forces it on, or by software through an active-low mode bit when configuration allows that. When the watchdog count overflows, the block pulses a reset request. A clear-watchdog strobe and a sleep strobe restart the watchdog. Each also updates two status flags, a time-out flag (TF) and a power flag (PF), which let software tell the reset causes apart.

The division ratio moves by one step between the two owners. From the same three select bits, the counter sees 1:2 up to 1:256, and the watchdog sees 1:1 up to 1:128.

Top module: `rtc_wdog`

## Requirements
- R1: The mode register is written through `modeWe`/`modeWdata` and holds these fields: bits 2:0 = PS, bit 3 = prescaler owner (0 counter, 1 watchdog), bit 4 = pin edge (0 rising, 1 falling), bit 5 = source (0 `instrTick`, 1 pin), bit 7 = active-low software watchdog enable. While bit 3 is 0, the counter advances once per 2^(PS+1) source events, and the watchdog advances on every base tick.
- R2: While bit 3 is 1, the watchdog advances once per 2^PS base ticks, and the counter advances on every source event.
- R3: While bit 5 is 1, `instrTick` has no effect on the counter.
- R4: The pin passes through two flops. With bit 4 = 0 only low-to-high transitions count. With bit 4 = 1 only high-to-low transitions count.
- R5: A counter write loads `cntWdata` and, while bit 3 is 0, clears the prescaler. The counter wraps from FFh to 00h.
- R6: The watchdog runs when `cfgWdogForce` = 1, or when `cfgWdogSwAllow` = 1 and bit 7 = 0. Otherwise base ticks have no effect. After 2^8 watchdog increments from a clear, `wdogRst` is high for one cycle.
- R7: `clrWdog` clears the watchdog count, and clears the prescaler while bit 3 is 1. It sets TF=1 and PF=1.
- R8: `sleepCmd` clears the watchdog count, enters the sleep state, and sets TF=1 and PF=0.
- R9: A watchdog reset sets the mode register to FFh and leaves the sleep state. It sets TF=0. It sets PF=1 when awake and PF=0 when asleep.
- R10: `mclrPulse` sets the mode register to FFh and leaves the sleep state. The flags stay unchanged when awake. When asleep it sets TF=1 and PF=0.
- R11: Power-on reset (`rstN` low) sets the mode register to FFh, the counter to 00h, and both flags to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| mclrPulse | input | 1 | Master-clear request, one cycle |
| cfgWdogForce | input | 1 | Configuration: watchdog always on |
| cfgWdogSwAllow | input | 1 | Configuration: software may enable watchdog |
| modeWe | input | 1 | Mode register write strobe |
| modeWdata | input | 8 | Mode register write data |
| cntWe | input | 1 | Counter write strobe |
| cntWdata | input | 8 | Counter write data |
| cntQ | output | 8 | Counter value |
| clrWdog | input | 1 | Clear-watchdog strobe |
| sleepCmd | input | 1 | Sleep strobe |
| extPin | input | 1 | External count pin, asynchronous |
| instrTick | input | 1 | Instruction-cycle enable |
| wdogTick | input | 1 | Watchdog base tick |
| wdogRst | output | 1 | Watchdog reset request pulse |
| flagTf | output | 1 | Time-out flag |
| flagPf | output | 1 | Power flag |

## Verification
Some properties are checked on every cycle:
- a counter write lands the written value on the next cycle;
- otherwise the counter either holds or steps by exactly one, with wrap;
- the reset request is a single-cycle pulse;
- the flag values follow each reset request, sleep strobe and clear strobe.

Other behaviours can only be shown by the bench scenarios:
- the division ratios for each owner and PS value;
- the one-step shift in ratio between the two owners;
- which pin edge counts;
- when the prescaler is cleared;
- the enable combinations;
- the full sequence of flag states across sleep, master clear and watchdog expiry.

// File: rtl/rtc_wdog_pkg.sv
package rtc_wdog_pkg;
  localparam int PRE_W = 8;
  localparam int PS_W  = $clog2(PRE_W);

  typedef struct packed {
    logic            tmrStep;
    logic            wdStep;
    logic            preToWd;
    logic [PS_W-1:0] psSel;
    logic            clrPre;
    logic            clrWd;
    logic            load;
  } rtcwStrobe_t;
endpackage

// File: rtl/rtc_wdog_ctrl.sv
module rtc_wdog_ctrl
  import rtc_wdog_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        mclrPulse,
  input  logic        cfgWdogForce,
  input  logic        cfgWdogSwAllow,
  input  logic        modeWe,
  input  logic [7:0]  modeWdata,
  input  logic        cntWe,
  input  logic        clrWdog,
  input  logic        sleepCmd,
  input  logic        extPin,
  input  logic        instrTick,
  input  logic        wdogTick,
  input  logic        wdWrap,
  output rtcwStrobe_t strb,
  output logic        wdogRst,
  output logic        flagTf,
  output logic        flagPf
);
  logic [7:0]      modeQ;
  logic [SYNC_N:0] pinSh;
  logic            asleep;
  logic            rstEvt, pinRise, pinFall, pinEdge, wdEn;
  logic            unusedModeBit;

  assign unusedModeBit = modeQ[6];
  assign rstEvt = wdogRst | mclrPulse;

  // synchroniser chain plus one history flop for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinSh <= '0;
    else       pinSh <= {pinSh[SYNC_N-1:0], extPin};
  end

  assign pinRise = pinSh[SYNC_N-1] & ~pinSh[SYNC_N];
  assign pinFall = ~pinSh[SYNC_N-1] & pinSh[SYNC_N];
  assign pinEdge = modeQ[4] ? pinFall : pinRise;
  assign wdEn    = cfgWdogForce | (cfgWdogSwAllow & ~modeQ[7]);

  always_comb begin
    strb.tmrStep = modeQ[5] ? pinEdge : instrTick;
    strb.wdStep  = wdogTick & wdEn & ~wdogRst;
    strb.preToWd = modeQ[3];
    strb.psSel   = modeQ[PS_W-1:0];
    strb.clrPre  = rstEvt | (cntWe & ~modeQ[3]) | ((clrWdog | sleepCmd) & modeQ[3]);
    strb.clrWd   = rstEvt | clrWdog | sleepCmd;
    strb.load    = cntWe;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            modeQ <= 8'hFF;
    else if (rstEvt)      modeQ <= 8'hFF;
    else if (modeWe)      modeQ <= modeWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wdogRst <= 1'b0;
    else       wdogRst <= wdWrap;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         asleep <= 1'b0;
    else if (rstEvt)   asleep <= 1'b0;
    else if (sleepCmd) asleep <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagTf <= 1'b1;
      flagPf <= 1'b1;
    end else if (wdogRst) begin
      flagTf <= 1'b0;
      flagPf <= ~asleep;
    end else if (mclrPulse) begin
      if (asleep) begin
        flagTf <= 1'b1;
        flagPf <= 1'b0;
      end
    end else if (sleepCmd) begin
      flagTf <= 1'b1;
      flagPf <= 1'b0;
    end else if (clrWdog) begin
      flagTf <= 1'b1;
      flagPf <= 1'b1;
    end
  end
endmodule

// File: rtl/rtc_wdog_dp.sv
module rtc_wdog_dp
  import rtc_wdog_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int WD_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  rtcwStrobe_t      strb,
  input  logic [CNT_W-1:0] cntWdata,
  output logic [CNT_W-1:0] cntQ,
  output logic             wdWrap
);
  logic [PRE_W-1:0] preQ, tMask, wMask;
  logic [PRE_W:0]   tWide;
  logic [WD_W-1:0]  wdQ;
  logic             preEv, tHit, wHit, tmrInc, wdInc;

  // counter owner divides by 2^(PS+1), watchdog owner by 2^PS
  always_comb begin
    tWide = ((PRE_W+1)'(2) << strb.psSel) - (PRE_W+1)'(1);
    tMask = tWide[PRE_W-1:0];
    wMask = (PRE_W'(1) << strb.psSel) - PRE_W'(1);
  end

  assign tHit   = (preQ & tMask) == tMask;
  assign wHit   = (preQ & wMask) == wMask;
  assign preEv  = strb.preToWd ? strb.wdStep : strb.tmrStep;
  assign tmrInc = strb.tmrStep & (strb.preToWd | tHit);
  assign wdInc  = strb.wdStep & (~strb.preToWd | wHit);
  assign wdWrap = wdInc & (&wdQ) & ~strb.clrWd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            preQ <= '0;
    else if (strb.clrPre) preQ <= '0;
    else if (preEv)       preQ <= preQ + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cntQ <= '0;
    else if (strb.load) cntQ <= cntWdata;
    else if (tmrInc)    cntQ <= cntQ + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           wdQ <= '0;
    else if (strb.clrWd) wdQ <= '0;
    else if (wdInc)      wdQ <= wdQ + WD_W'(1);
  end
endmodule

// File: rtl/rtc_wdog.sv
module rtc_wdog
  import rtc_wdog_pkg::*;
#(
  parameter int WD_W   = 8,
  parameter int SYNC_N = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       mclrPulse,
  input  logic       cfgWdogForce,
  input  logic       cfgWdogSwAllow,
  input  logic       modeWe,
  input  logic [7:0] modeWdata,
  input  logic       cntWe,
  input  logic [7:0] cntWdata,
  output logic [7:0] cntQ,
  input  logic       clrWdog,
  input  logic       sleepCmd,
  input  logic       extPin,
  input  logic       instrTick,
  input  logic       wdogTick,
  output logic       wdogRst,
  output logic       flagTf,
  output logic       flagPf
);
  rtcwStrobe_t strb;
  logic        wdWrap;

  rtc_wdog_ctrl #(.SYNC_N(SYNC_N)) u_ctrl (
    .clk(clk), .rstN(rstN), .mclrPulse(mclrPulse),
    .cfgWdogForce(cfgWdogForce), .cfgWdogSwAllow(cfgWdogSwAllow),
    .modeWe(modeWe), .modeWdata(modeWdata), .cntWe(cntWe),
    .clrWdog(clrWdog), .sleepCmd(sleepCmd), .extPin(extPin),
    .instrTick(instrTick), .wdogTick(wdogTick), .wdWrap(wdWrap),
    .strb(strb), .wdogRst(wdogRst), .flagTf(flagTf), .flagPf(flagPf)
  );

  rtc_wdog_dp #(.CNT_W(8), .WD_W(WD_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cntWdata(cntWdata),
    .cntQ(cntQ), .wdWrap(wdWrap)
  );
endmodule

// File: rtl/rtc_wdog_chk.sv
module rtc_wdog_chk (
  input logic       clk,
  input logic       rstN,
  input logic       mclrPulse,
  input logic       cfgWdogForce,
  input logic       cfgWdogSwAllow,
  input logic       modeWe,
  input logic [7:0] modeWdata,
  input logic       cntWe,
  input logic [7:0] cntWdata,
  input logic [7:0] cntQ,
  input logic       clrWdog,
  input logic       sleepCmd,
  input logic       extPin,
  input logic       instrTick,
  input logic       wdogTick,
  input logic       wdogRst,
  input logic       flagTf,
  input logic       flagPf
);
  // R5: a write lands on the next cycle
  p_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    cntWe |=> cntQ == $past(cntWdata));
  // R5: without a write the counter holds or steps by one, wrapping
  p_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    !cntWe |=> (cntQ == $past(cntQ)) || (cntQ == $past(cntQ) + 8'd1));
  // R6: reset request lasts a single cycle
  p_wdrst_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    wdogRst |=> !wdogRst);
  // R9: watchdog reset clears the time-out flag
  p_wd_flags_r9: assert property (@(posedge clk) disable iff (!rstN)
    wdogRst |=> !flagTf);
  // R8: sleep flag pattern
  p_sleep_flags_r8: assert property (@(posedge clk) disable iff (!rstN)
    (sleepCmd && !wdogRst && !mclrPulse) |=> (flagTf && !flagPf));
  // R7: clear-watchdog flag pattern
  p_clr_flags_r7: assert property (@(posedge clk) disable iff (!rstN)
    (clrWdog && !sleepCmd && !wdogRst && !mclrPulse) |=> (flagTf && flagPf));
endmodule

bind rtc_wdog rtc_wdog_chk u_chk (.*);

// File: tb/rtc_wdog_tb.sv
module rtc_wdog_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mclrPulse = 0, cfgWdogForce = 0, cfgWdogSwAllow = 1;
  logic modeWe = 0, cntWe = 0, clrWdog = 0, sleepCmd = 0;
  logic extPin = 0, instrTick = 0, wdogTick = 0;
  logic [7:0] modeWdata = 0, cntWdata = 0;
  logic [7:0] cntQ;
  logic wdogRst, flagTf, flagPf;
  int checks = 0, failures = 0;
  int n;

  always #4 clk = ~clk;

  rtc_wdog u_dut (.*);

  // {mode, start value, instruction ticks, expected count}
  localparam logic [39:0] VEC [0:5] = '{
    {8'h00, 8'h10, 16'd7,   8'h13},  // R1 1:2
    {8'h02, 8'h00, 16'd20,  8'h02},  // R1 1:8
    {8'h07, 8'h05, 16'd255, 8'h05},  // R1 1:256 just short
    {8'h07, 8'h05, 16'd256, 8'h06},  // R1 1:256 exact
    {8'h08, 8'hFE, 16'd3,   8'h01},  // R2 counter undivided, R5 wrap
    {8'h28, 8'h40, 16'd10,  8'h40}   // R3 instr ticks ignored
  };

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wrMode(input logic [7:0] v);
    @(negedge clk); modeWe = 1; modeWdata = v;
    @(negedge clk); modeWe = 0;
  endtask

  task automatic wrCnt(input logic [7:0] v);
    @(negedge clk); cntWe = 1; cntWdata = v;
    @(negedge clk); cntWe = 0;
  endtask

  task automatic ticks(input int k);
    for (int i = 0; i < k; i++) begin @(negedge clk); instrTick = 1; end
    @(negedge clk); instrTick = 0;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1;
    @(negedge clk); s = 0;
  endtask

  task automatic wdTicks(input int k);
    for (int i = 0; i < k; i++) begin @(negedge clk); wdogTick = 1; end
    @(negedge clk); wdogTick = 0;
  endtask

  task automatic pinSet(input logic v);
    @(negedge clk); extPin = v;
    repeat (6) @(negedge clk);
  endtask

  // holds the base tick until the reset request appears; -1 when none by cap
  task automatic runWd(input int cap, output int cnt);
    logic found = 0;
    cnt = 0;
    @(negedge clk); wdogTick = 1;
    while (!found && cnt < cap) begin
      @(posedge clk); cnt++;
      @(negedge clk);
      if (wdogRst) found = 1;
    end
    wdogTick = 0;
    if (!found) cnt = -1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R11 counter", cntQ, 8'h00);
    check("R11 TF", flagTf, 1);
    check("R11 PF", flagPf, 1);
    check("R11 wdogRst", wdogRst, 0);
    ticks(5);
    check("R11 mode FFh selects pin source", cntQ, 8'h00);

    for (int v = 0; v < 6; v++) begin
      wrMode(VEC[v][39:32]);
      wrCnt(VEC[v][31:24]);
      ticks(int'(VEC[v][23:8]));
      check($sformatf("R1/R2/R3 vector %0d", v), cntQ, VEC[v][7:0]);
    end

    // R5 prescaler cleared by counter write
    wrMode(8'h01); wrCnt(8'h00); ticks(3);
    wrCnt(8'h00); ticks(1);
    check("R5 prescaler cleared", cntQ, 8'h00);
    ticks(3);
    check("R5 after four", cntQ, 8'h01);

    // R4 edge selection
    wrMode(8'h28); wrCnt(8'h00);
    pinSet(1); check("R4 rising counted", cntQ, 8'h01);
    pinSet(0); check("R4 falling ignored", cntQ, 8'h01);
    wrMode(8'h38); wrCnt(8'h00);
    pinSet(1); check("R4 rising ignored", cntQ, 8'h00);
    pinSet(0); check("R4 falling counted", cntQ, 8'h01);

    // R6/R9 watchdog expiry, owner and ratios
    wrMode(8'h08); pulse(clrWdog);
    check("R7 clr TF", flagTf, 1); check("R7 clr PF", flagPf, 1);
    runWd(40000, n); check("R6 expiry 1:1", n, 256);
    check("R9 awake TF", flagTf, 0); check("R9 awake PF", flagPf, 1);
    runWd(600, n); check("R9 mode reset disables sw watchdog", n, -1);
    wrMode(8'h0A); runWd(40000, n); check("R2 watchdog 1:4", n, 1024);
    wrMode(8'h07); runWd(40000, n); check("R1 watchdog undivided", n, 256);
    wrMode(8'h0A); wdTicks(3); pulse(clrWdog);
    runWd(40000, n); check("R7 prescaler cleared", n, 1024);
    cfgWdogSwAllow = 0;
    wrMode(8'h08); runWd(600, n); check("R6 sw enable forbidden", n, -1);
    cfgWdogForce = 1;
    wrMode(8'h88); runWd(40000, n); check("R6 forced on", n, 256);
    cfgWdogForce = 0; cfgWdogSwAllow = 1;

    // R8/R9/R10 flag sequences
    wrMode(8'h08); wdTicks(5); pulse(sleepCmd);
    check("R8 sleep TF", flagTf, 1); check("R8 sleep PF", flagPf, 0);
    runWd(40000, n); check("R8 sleep clears count", n, 256);
    check("R9 asleep TF", flagTf, 0); check("R9 asleep PF", flagPf, 0);
    wrMode(8'h08); runWd(40000, n);
    check("R9 woke PF", flagPf, 1);
    pulse(mclrPulse);
    check("R10 awake TF held", flagTf, 0); check("R10 awake PF held", flagPf, 1);
    runWd(600, n); check("R10 mode FFh after mclr", n, -1);
    pulse(sleepCmd); pulse(mclrPulse);
    check("R10 asleep TF", flagTf, 1); check("R10 asleep PF", flagPf, 0);
    wrMode(8'h08); runWd(40000, n);
    check("R10 mclr wakes", flagPf, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule